// File: doc/BRIEF.md
# Strobe-Serial to Trigger-Handshake Message Adapter

This block joins two modules that move the same two-byte message but use different cycle-level conventions. The producer side marks a message with a one-cycle strobe. The first byte travels in the strobe cycle, and the second byte follows in the very next cycle with the strobe low. Any number of idle strobe-low cycles may come before a message, and the bus is meaningless in those cycles.

The consumer side expects the first byte on its bus while a trigger line is high. The second byte must follow directly afterwards while the trigger is low. Each byte stays on the bus for a configurable number of cycles, and the bus is zero whenever no message is being presented.

The adapter captures both bytes, waits until the second one is held, and then plays the pair out with the required trigger levels. It carries one message at a time. A strobe that arrives while a message is still being captured or presented is discarded, and a one-cycle overrun pulse is raised for it.

Top module: `ser2hs_adapter`

## Requirements
- R1: While reset is low and after it is released, trig_out is 0, data_out is all zeros and overrun is 0 until a message is accepted.
- R2: For an accepted strobe in cycle N, trig_out first reads 1 in cycle N+2, with data_out equal to the byte that was on data_in in cycle N.
- R3: trig_out stays 1 for exactly HOLD consecutive cycles, and data_out holds the first byte unchanged for all of them.
- R4: In the cycle right after the last trigger-high cycle, data_out shows the byte that was on data_in in cycle N+1, with trig_out 0. It keeps that value for exactly HOLD cycles.
- R5: Outside a message presentation, trig_out is 0 and data_out is all zeros.
- R6: A strobe in any cycle from N+1 through N+1+2*HOLD is dropped, and overrun reads 1 in the cycle after that strobe only. The message in progress is presented unchanged, and the dropped bytes never appear.
- R7: A strobe in cycle N+2+2*HOLD is accepted, so messages can follow each other without a gap cycle beyond that one.
- R8: While idle, data_in values with strobe low change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_in | input | 1 | High for one cycle when the first byte is on data_in |
| data_in | input | W (8) | Producer byte bus |
| trig_out | output | 1 | High while the first byte is presented |
| data_out | output | W (8) | Consumer byte bus, zero when idle |
| overrun | output | 1 | One-cycle pulse for each dropped strobe |

## Verification
The embedded assertions check four things on every cycle. The trigger rises exactly two cycles after a strobe. A trigger-high run lasts exactly HOLD cycles. The bus is steady during that run. Every overrun pulse is preceded by a strobe. Whether the correct bytes appear, and in the correct order, can only be shown by the bench's scoreboard. The same holds for dropped messages leaving no trace, idle bus values having no effect, and the exact boundary between a rejected strobe and an accepted back-to-back strobe.

// File: rtl/ser2hs_adapter.sv
module ser2hs_adapter #(
  parameter int W    = 8,
  parameter int HOLD = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_in,
  input  logic [W-1:0] data_in,
  output logic         trig_out,
  output logic [W-1:0] data_out,
  output logic         overrun
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  typedef enum logic [1:0] {S_IDLE, S_GRAB, S_A, S_B} st_t;

  st_t           st;
  logic [W-1:0]  first_q, second_q;
  logic [CW-1:0] cnt;
  logic          last;

  assign last     = (cnt == CW'(HOLD - 1));
  assign trig_out = (st == S_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      first_q  <= '0;
      second_q <= '0;
      cnt      <= '0;
      data_out <= '0;
      overrun  <= 1'b0;
    end else begin
      overrun <= strobe_in && (st != S_IDLE);
      case (st)
        S_IDLE: if (strobe_in) begin
          first_q <= data_in;
          st      <= S_GRAB;
        end
        S_GRAB: begin
          second_q <= data_in;
          data_out <= first_q;
          cnt      <= '0;
          st       <= S_A;
        end
        S_A: if (last) begin
          data_out <= second_q;
          cnt      <= '0;
          st       <= S_B;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (last) begin
          data_out <= '0;
          cnt      <= '0;
          st       <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  logic [CW:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= trig_out ? hi_run + 1'b1 : '0;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $past(strobe_in, 2));

  assert_a_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (hi_run < (CW+1)'(HOLD)));

  assert_a_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_out) |-> (hi_run == (CW+1)'(HOLD)));

  assert_a_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(trig_out)) |-> $stable(data_out));

  assert_ovr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(strobe_in));
endmodule

// File: tb/test_ser2hs_adapter.sv
module test_ser2hs_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int HOLD = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strobe_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         trig_out;
  logic [W-1:0] data_out;
  logic         overrun;

  ser2hs_adapter #(.W(W), .HOLD(HOLD)) i_ser2hs_adapter (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .data_in(data_in),
    .trig_out(trig_out), .data_out(data_out), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int t0; logic [W-1:0] a; logic [W-1:0] b; } msg_t;
  msg_t msg_q[$];
  int   ovr_q[$];
  int   cyc = 0, checks = 0, errors = 0, busy_end = -1;
  bit   mon_on = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe_in = 1'b0;
      data_in   = W'($urandom);
    end
  endtask

  task automatic send(logic [W-1:0] a, logic [W-1:0] b);
    msg_t m;
    @(negedge clk);
    strobe_in = 1'b1;
    data_in   = a;
    if (cyc > busy_end) begin
      m.t0 = cyc; m.a = a; m.b = b;
      msg_q.push_back(m);
      busy_end = cyc + 1 + 2*HOLD;
    end else begin
      ovr_q.push_back(cyc + 1);
    end
    @(negedge clk);
    strobe_in = 1'b0;
    data_in   = b;
  endtask

  initial begin : monitor
    int   phase = 0, cnt = 0;
    msg_t cur;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (overrun) begin
          check(ovr_q.size() > 0 && ovr_q[0] == cyc, "R6 overrun timing", cyc,
                ovr_q.size() > 0 ? ovr_q[0] : -1);
          if (ovr_q.size() > 0) void'(ovr_q.pop_front());
        end else if (ovr_q.size() > 0 && ovr_q[0] < cyc) begin
          check(0, "R6 missing overrun", 0, ovr_q[0]);
          void'(ovr_q.pop_front());
        end
        case (phase)
          0: if (trig_out) begin
               if (msg_q.size() == 0) begin
                 check(0, "R6 unexpected message", data_out, 0);
               end else begin
                 cur = msg_q.pop_front();
                 check(cyc == cur.t0 + 2, "R2 latency", cyc, cur.t0 + 2);
                 check(data_out == cur.a, "R2 first byte", data_out, cur.a);
                 phase = 1; cnt = 1;
               end
             end else begin
               check(data_out == '0, "R5/R8 idle bus", data_out, 0);
             end
          1: if (cnt < HOLD) begin
               check(trig_out && data_out == cur.a, "R3 first byte held",
                     {trig_out, data_out}, {1'b1, cur.a});
               cnt++;
             end else begin
               check(!trig_out && data_out == cur.b, "R4 second byte",
                     {trig_out, data_out}, {1'b0, cur.b});
               phase = 2; cnt = 1;
             end
          default: if (cnt < HOLD) begin
               check(!trig_out && data_out == cur.b, "R4 second byte held",
                     {trig_out, data_out}, {1'b0, cur.b});
               cnt++;
             end else begin
               check(!trig_out && data_out == '0, "R5 idle after message",
                     {trig_out, data_out}, 0);
               phase = 0;
             end
        endcase
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(!trig_out && data_out == '0 && !overrun, "R1 reset outputs",
          {overrun, trig_out, data_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!trig_out && data_out == '0 && !overrun, "R1 after release",
          {overrun, trig_out, data_out}, 0);
    mon_on = 1;
    idle(6);                          // R8: junk bus with strobe low
    send(8'h11, 8'h22);               // R2 R3 R4
    idle(12);
    send(8'hA5, 8'h5A);
    send(8'hFF, 8'hEE);               // R6: strobe during capture/present
    idle(14);
    send(8'h01, 8'h80);
    idle(2*HOLD - 1);
    send(8'h33, 8'h44);               // R6: last busy cycle, dropped
    idle(12);
    send(8'h5C, 8'hC5);
    idle(2*HOLD);
    send(8'h77, 8'h88);               // R7: first free cycle, accepted
    idle(2*HOLD);
    send(8'h00, 8'hFF);               // R7 again, zero first byte
    for (int i = 0; i < 6; i++) begin
      send(W'($urandom), W'($urandom));
      idle(2*HOLD + i);
    end
    idle(20);
    check(msg_q.size() == 0, "R2 all messages presented", msg_q.size(), 0);
    check(ovr_q.size() == 0, "R6 all overruns seen", ovr_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule